// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO Buffer

This block buffers 18-bit words between two clock domains. The domains may be unrelated or may share one clock. The producer side stores a word when both of its enables are in their active states and the block reports room. The consumer side works in fall-through style. The oldest stored word appears on the registered data output without any request, and a ready flag marks it as valid. Three active-low qualifiers must all be low to consume that word and let the next one advance.

Both write and read pointers cross domains as Gray code through two-flop synchronizers. Every flag therefore errs on the safe side while a crossing is still in flight. A half-full flag and a combined near-full/near-empty flag are derived in the write domain, using a margin taken from a static input. A single active-high reset is synchronized separately into each domain. It must be held for at least four rising edges of each clock, and it puts every flag into a fixed state. The total capacity is 512 words, and the word held in the output register counts toward it.

Top module: `dcfifo_ft`

## Requirements
- R1: A word is stored at a rising `wr_clk` edge only when `wr_en_p` is 1, `wr_en_n` is 0 and `wr_ready` is 1. With any other combination, no word is added to the sequence later delivered.
- R2: At a rising `rd_clk` edge the output word is consumed only when `rd_en_n`, `rd_gate1_n` and `rd_gate2_n` are all 0 and `rd_valid` is 1. Otherwise `rd_valid` and `rd_data` hold their values.
- R3: The first word written into an empty buffer appears on `rd_data` with `rd_valid` at 1, while all three read qualifiers are held at 1.
- R4: Words leave in the order they were accepted, each exactly once, with no change to their 18 bits.
- R5: The buffer accepts exactly 512 words, counting the one in the output register. `wr_ready` is 0 while 512 are stored and returns to 1 after a word is consumed.
- R6: After the last stored word is consumed, `rd_valid` goes to 0 and stays 0 until a new word arrives.
- R7: Once the crossings settle, `half_full` is 1 exactly when the stored count is 257 or more.
- R8: Once the crossings settle, `near_limit` is 1 exactly when the stored count is at most `margin` or at least 512 minus `margin`.
- R9: Once `rst` has been 1 for four rising edges of each clock, `wr_ready`, `rd_valid` and `half_full` read 0 and `near_limit` reads 1. The stored contents are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst | input | 1 | Active-high reset, synchronized into both domains |
| margin | input | 9 | Static count margin for the near-limit flag |
| wr_data | input | 18 | Word to store |
| wr_en_p | input | 1 | Write enable, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wr_ready | output | 1 | Room for a word (write domain) |
| rd_en_n | input | 1 | Read request, active low |
| rd_gate1_n | input | 1 | First read qualifier, active low |
| rd_gate2_n | input | 1 | Second read qualifier, active low |
| rd_data | output | 18 | Registered oldest word |
| rd_valid | output | 1 | `rd_data` holds a valid word (read domain) |
| half_full | output | 1 | Stored count at least 257 |
| near_limit | output | 1 | Stored count within `margin` of empty or full |

## Verification
A corrupted write or read pointer shows up on `rd_data` at the next consumed word, as a repeated, skipped or reordered value. It can also show as a word count that no longer adds up to 512 at the full point. A wrong level in the write domain shows in `half_full`, `near_limit` or `wr_ready` within a few clocks of each domain, once the Gray crossings settle. A fault in the fall-through register shows as `rd_valid` staying low with qualifiers inactive, or as `rd_data` changing while no read is made.

// File: rtl/dcfifo_ft_pkg.sv
package dcfifo_ft_pkg;

  localparam int unsigned CODE_W = 32;

  function automatic logic [CODE_W-1:0] bin_to_gray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] gray_to_bin(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
// Multi-stage synchronizer; also used as a reset synchronizer with rst tied low.
module dcfifo_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
// Simple dual-port storage, registered read, one port per clock.
module dcfifo_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIDTH = 18,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_wr_side.sv
// Write-domain control: pointer, room flag and level flags.
module dcfifo_wr_side
  import dcfifo_ft_pkg::*;
#(
  parameter int unsigned DEPTH      = 512,
  parameter int unsigned HALF_LEVEL = DEPTH / 2 + 1,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned PW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_p,
  input  logic          en_n,
  input  logic [AW-1:0] margin,
  input  logic [PW-1:0] cons_gray,
  output logic          wr_ready,
  output logic          half_full,
  output logic          near_limit,
  output logic [PW-1:0] ptr_gray,
  output logic [PW-1:0] ptr_bin,
  output logic [PW-1:0] level,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr
);
  logic [PW-1:0] ptr_q, ptr_nx, gray_q, cons_bin, level_nx, margin_x, hi_mark;
  logic          ready_q, hf_q, near_q, push;

  assign push     = en_p & ~en_n & ready_q;
  assign cons_bin = PW'(gray_to_bin(CODE_W'(cons_gray)));
  assign ptr_nx   = ptr_q + PW'(push);
  assign level_nx = ptr_nx - cons_bin;
  assign margin_x = PW'(margin);
  assign hi_mark  = PW'(DEPTH) - margin_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      gray_q  <= '0;
      ready_q <= 1'b0;
      hf_q    <= 1'b0;
      near_q  <= 1'b1;
    end else begin
      ptr_q   <= ptr_nx;
      gray_q  <= PW'(bin_to_gray(CODE_W'(ptr_nx)));
      ready_q <= (level_nx != PW'(DEPTH));
      hf_q    <= (level_nx >= PW'(HALF_LEVEL));
      near_q  <= (level_nx <= margin_x) || (level_nx >= hi_mark);
    end
  end

  assign wr_ready   = ready_q;
  assign half_full  = hf_q;
  assign near_limit = near_q;
  assign ptr_gray   = gray_q;
  assign ptr_bin    = ptr_q;
  assign level      = ptr_q - cons_bin;
  assign mem_we     = push;
  assign mem_addr   = ptr_q[AW-1:0];
endmodule

// File: rtl/dcfifo_rd_side.sv
// Read-domain control: fall-through output register and consumed pointer.
module dcfifo_rd_side
  import dcfifo_ft_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIDTH = 18,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic             gate1_n,
  input  logic             gate2_n,
  input  logic [PW-1:0]    wptr_gray,
  input  logic [WIDTH-1:0] mem_q,
  output logic [AW-1:0]    mem_raddr,
  output logic [PW-1:0]    cons_gray,
  output logic             mem_empty,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  logic [PW-1:0]    rptr_q, rptr_nx, cons_q, cons_nx, cgray_q, wptr_bin;
  logic             valid_q, fire, load;
  logic [WIDTH-1:0] data_q;

  assign wptr_bin  = PW'(gray_to_bin(CODE_W'(wptr_gray)));
  assign mem_empty = (rptr_q == wptr_bin);
  assign fire      = valid_q & ~en_n & ~gate1_n & ~gate2_n;
  assign load      = ~mem_empty & (~valid_q | fire);
  assign rptr_nx   = rptr_q + PW'(load);
  assign cons_nx   = cons_q + PW'(fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q  <= '0;
      cons_q  <= '0;
      cgray_q <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      rptr_q  <= rptr_nx;
      cons_q  <= cons_nx;
      cgray_q <= PW'(bin_to_gray(CODE_W'(cons_nx)));
      if (load) begin
        valid_q <= 1'b1;
        data_q  <= mem_q;
      end else if (fire) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign mem_raddr = rptr_nx[AW-1:0];
  assign cons_gray = cgray_q;
  assign rd_valid  = valid_q;
  assign rd_data   = data_q;
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int unsigned DEPTH       = 512,
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned PW         = AW + 1
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst,
  input  logic [AW-1:0]    margin,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en_p,
  input  logic             wr_en_n,
  output logic             wr_ready,
  input  logic             rd_en_n,
  input  logic             rd_gate1_n,
  input  logic             rd_gate2_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             half_full,
  output logic             near_limit
);
  logic             w_rst, r_rst;
  logic [PW-1:0]    wptr_gray, wptr_bin, wr_level, cons_gray;
  logic [PW-1:0]    wptr_gray_rd, cons_gray_wr;
  logic             mem_we, mem_empty;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [WIDTH-1:0] mem_q;

  dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
    .clk(wr_clk), .rst(1'b0), .d(rst), .q(w_rst)
  );
  dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst (
    .clk(rd_clk), .rst(1'b0), .d(rst), .q(r_rst)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(r_rst), .d(wptr_gray), .q(wptr_gray_rd)
  );
  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(w_rst), .d(cons_gray), .q(cons_gray_wr)
  );

  dcfifo_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst(w_rst), .en_p(wr_en_p), .en_n(wr_en_n),
    .margin(margin), .cons_gray(cons_gray_wr),
    .wr_ready(wr_ready), .half_full(half_full), .near_limit(near_limit),
    .ptr_gray(wptr_gray), .ptr_bin(wptr_bin), .level(wr_level),
    .mem_we(mem_we), .mem_addr(mem_waddr)
  );

  dcfifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .rclk(rd_clk), .raddr(mem_raddr), .rdata(mem_q)
  );

  dcfifo_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
    .clk(rd_clk), .rst(r_rst), .en_n(rd_en_n), .gate1_n(rd_gate1_n),
    .gate2_n(rd_gate2_n), .wptr_gray(wptr_gray_rd), .mem_q(mem_q),
    .mem_raddr(mem_raddr), .cons_gray(cons_gray), .mem_empty(mem_empty),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/dcfifo_ft_chk.sv
module dcfifo_ft_chk #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WIDTH = 18,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             w_rst,
  input logic             r_rst,
  input logic             wr_en_p,
  input logic             wr_en_n,
  input logic             wr_ready,
  input logic [PW-1:0]    wr_ptr,
  input logic [PW-1:0]    wr_level,
  input logic             rd_en_n,
  input logic             rd_gate1_n,
  input logic             rd_gate2_n,
  input logic             rd_valid,
  input logic [WIDTH-1:0] rd_data,
  input logic             mem_empty,
  input logic             half_full,
  input logic             near_limit
);
  logic rd_take;
  assign rd_take = rd_valid & ~rd_en_n & ~rd_gate1_n & ~rd_gate2_n;

  // R1
  write_gate_chk: assert property (@(posedge wr_clk) disable iff (w_rst)
    !(wr_en_p && !wr_en_n && wr_ready) |=> $stable(wr_ptr));

  // R5
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (w_rst)
    wr_level <= PW'(DEPTH));

  // R5
  full_blocks_chk: assert property (@(posedge wr_clk) disable iff (w_rst)
    (wr_level == PW'(DEPTH)) |-> !wr_ready);

  // R2
  read_hold_chk: assert property (@(posedge rd_clk) disable iff (r_rst)
    (rd_valid && !rd_take) |=> (rd_valid && $stable(rd_data)));

  // R6
  empty_stays_chk: assert property (@(posedge rd_clk) disable iff (r_rst)
    (mem_empty && !rd_valid) |=> !rd_valid);

  // R9
  wr_reset_state_chk: assert property (@(posedge wr_clk)
    w_rst |=> (!wr_ready && !half_full && near_limit));

  // R9
  rd_reset_state_chk: assert property (@(posedge rd_clk)
    r_rst |=> !rd_valid);
endmodule

bind dcfifo_ft dcfifo_ft_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .w_rst(w_rst), .r_rst(r_rst),
  .wr_en_p(wr_en_p), .wr_en_n(wr_en_n), .wr_ready(wr_ready),
  .wr_ptr(wptr_bin), .wr_level(wr_level),
  .rd_en_n(rd_en_n), .rd_gate1_n(rd_gate1_n), .rd_gate2_n(rd_gate2_n),
  .rd_valid(rd_valid), .rd_data(rd_data), .mem_empty(mem_empty),
  .half_full(half_full), .near_limit(near_limit)
);

// File: tb/dcfifo_ft_tb_top.sv
module dcfifo_ft_tb_top;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int DEPTH     = 512;
  localparam int WIDTH     = 18;
  localparam int AW        = 9;

  logic             wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
  logic [AW-1:0]    margin = 9'd32;
  logic [WIDTH-1:0] wr_data = '0;
  logic             wr_en_p = 1'b0, wr_en_n = 1'b1;
  logic             rd_en_n = 1'b1, rd_gate1_n = 1'b1, rd_gate2_n = 1'b1;
  logic             wr_ready, rd_valid, half_full, near_limit;
  logic [WIDTH-1:0] rd_data;

  always #(WR_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2) rd_clk = ~rd_clk;

  dcfifo_ft dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .margin(margin),
    .wr_data(wr_data), .wr_en_p(wr_en_p), .wr_en_n(wr_en_n), .wr_ready(wr_ready),
    .rd_en_n(rd_en_n), .rd_gate1_n(rd_gate1_n), .rd_gate2_n(rd_gate2_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .half_full(half_full),
    .near_limit(near_limit)
  );

  int               errors = 0;
  int               checks = 0;
  int               seq    = 0;
  bit               wr_done = 0;
  logic [WIDTH-1:0] model[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic bit exp_near(input int cnt, input int m);
    return (cnt <= m) || (cnt >= DEPTH - m);
  endfunction

  task automatic settle;
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic wr_one(input logic [WIDTH-1:0] d, output bit acc);
    @(negedge wr_clk);
    wr_data = d; wr_en_p = 1'b1; wr_en_n = 1'b0;
    acc = wr_ready;
    if (acc) model.push_back(d);
    @(posedge wr_clk);
    #1;
    wr_en_p = 1'b0; wr_en_n = 1'b1;
  endtask

  task automatic rd_one;
    @(negedge rd_clk);
    while (!rd_valid) @(negedge rd_clk);
    if (model.size() == 0) check(0, "R4", "pop with empty model", 1, 0);
    else check(rd_data == model[0], "R4", "popped word", int'(rd_data), int'(model[0]));
    rd_en_n = 1'b0; rd_gate1_n = 1'b0; rd_gate2_n = 1'b0;
    if (model.size() != 0) void'(model.pop_front());
    @(posedge rd_clk);
    #1;
    rd_en_n = 1'b1; rd_gate1_n = 1'b1; rd_gate2_n = 1'b1;
  endtask

  task automatic fill_to(input int target);
    bit acc;
    while (model.size() < target) begin
      seq++;
      wr_one(WIDTH'(seq * 37 + 5), acc);
    end
  endtask

  task automatic level_flags(input string tag);
    int c = model.size();
    settle();
    check(half_full == (c >= 257), "R7", {"half_full ", tag}, int'(half_full), int'(c >= 257));
    check(near_limit == exp_near(c, int'(margin)), "R8", {"near_limit ", tag},
          int'(near_limit), int'(exp_near(c, int'(margin))));
  endtask

  task automatic drain_all;
    while (model.size() != 0) rd_one();
    settle();
    check(!rd_valid, "R6", "rd_valid after drain", int'(rd_valid), 0);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
    // R9: flags during reset
    check(!wr_ready, "R9", "wr_ready in reset", int'(wr_ready), 0);
    check(!rd_valid, "R9", "rd_valid in reset", int'(rd_valid), 0);
    check(!half_full, "R9", "half_full in reset", int'(half_full), 0);
    check(near_limit, "R9", "near_limit in reset", int'(near_limit), 1);
    model.delete();
    rst = 1'b0;
    settle();
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    errors++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit acc;
    logic [WIDTH-1:0] held;
    void'($urandom(32'd20240611));

    do_reset();
    check(wr_ready, "R9", "wr_ready after reset", int'(wr_ready), 1);
    check(!rd_valid, "R6", "rd_valid empty", int'(rd_valid), 0);

    // R3: first word falls through with qualifiers inactive
    wr_one(18'h2A5A5, acc);
    settle();
    check(rd_valid, "R3", "rd_valid on first word", int'(rd_valid), 1);
    check(rd_data == 18'h2A5A5, "R3", "first word", int'(rd_data), 'h2A5A5);

    // R2: partial qualifier sets do not consume
    held = rd_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge rd_clk);
      rd_en_n = (k == 2); rd_gate1_n = (k == 1); rd_gate2_n = (k == 0);
      repeat (4) @(negedge rd_clk);
      check(rd_valid && rd_data == held, "R2", "partial qualifiers hold", int'(rd_data), int'(held));
    end
    rd_en_n = 1'b1; rd_gate1_n = 1'b1; rd_gate2_n = 1'b1;

    // R1: invalid enable pairs store nothing
    for (int k = 0; k < 3; k++) begin
      @(negedge wr_clk);
      wr_data = WIDTH'(k + 100);
      wr_en_p = (k == 1); wr_en_n = (k != 2);
      if (k == 2) wr_en_n = 1'b0;
      if (k == 2) wr_en_p = 1'b0;
    end
    @(negedge wr_clk);
    wr_en_p = 1'b0; wr_en_n = 1'b1;
    rd_one();
    settle();
    check(!rd_valid, "R1", "no word from invalid enables", int'(rd_valid), 0);

    // R7/R8/R5: fill through the thresholds
    level_flags("count 0");
    fill_to(32);  level_flags("count 32");
    fill_to(33);  level_flags("count 33");
    fill_to(256); level_flags("count 256");
    fill_to(257); level_flags("count 257");
    fill_to(479); level_flags("count 479");
    fill_to(480); level_flags("count 480");
    fill_to(512); level_flags("count 512");
    check(!wr_ready, "R5", "wr_ready at 512", int'(wr_ready), 0);
    wr_one(18'h3FFFF, acc);
    check(!acc, "R5", "write at full refused", int'(acc), 0);
    rd_one();
    settle();
    check(wr_ready, "R5", "wr_ready after one pop", int'(wr_ready), 1);
    check(model.size() == 511, "R5", "count after pop", model.size(), 511);
    drain_all();

    // R8 with another margin
    margin = 9'd100;
    settle();
    fill_to(100); level_flags("margin 100 count 100");
    fill_to(101); level_flags("margin 100 count 101");
    drain_all();
    margin = 9'd32;

    // R9: reset discards contents
    fill_to(5);
    settle();
    do_reset();
    check(!rd_valid, "R9", "contents discarded", int'(rd_valid), 0);

    // R4/R2/R1: random traffic across unrelated clocks
    fork
      begin
        for (int n = 0; n < 1500; n++) begin
          int r;
          @(negedge wr_clk);
          r = int'($urandom % 8);
          wr_data = WIDTH'($urandom);
          wr_en_p = (r < 5) || (r == 5);
          wr_en_n = (r >= 5) && (r != 6);
          if (r == 6) wr_en_p = 1'b0;
          if (wr_en_p && !wr_en_n && wr_ready) model.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en_p = 1'b0; wr_en_n = 1'b1;
        wr_done = 1;
      end
      begin
        bit hold = 0;
        logic [WIDTH-1:0] hval = '0;
        while (!wr_done || model.size() != 0) begin
          bit take;
          @(negedge rd_clk);
          if (hold)
            check(rd_valid && rd_data == hval, "R2", "held word unchanged", int'(rd_data), int'(hval));
          rd_en_n    = wr_done ? 1'b0 : ($urandom % 4 == 0);
          rd_gate1_n = wr_done ? 1'b0 : ($urandom % 4 == 0);
          rd_gate2_n = wr_done ? 1'b0 : ($urandom % 4 == 0);
          take = rd_valid && !rd_en_n && !rd_gate1_n && !rd_gate2_n;
          if (take) begin
            if (model.size() == 0) check(0, "R4", "random pop with empty model", 1, 0);
            else begin
              check(rd_data == model[0], "R4", "random order", int'(rd_data), int'(model[0]));
              void'(model.pop_front());
            end
          end
          hold = rd_valid && !take;
          hval = rd_data;
        end
        @(negedge rd_clk);
        rd_en_n = 1'b1; rd_gate1_n = 1'b1; rd_gate2_n = 1'b1;
      end
    join

    settle();
    check(!rd_valid, "R6", "empty after random", int'(rd_valid), 0);
    check(wr_ready, "R5", "room after random", int'(wr_ready), 1);
    check(!half_full, "R7", "half_full after random", int'(half_full), 0);
    check(near_limit, "R8", "near_limit after random", int'(near_limit), 1);
    finish_run();
  end
endmodule